// File: doc/BRIEF.md
# Word Buffer with Rewind and Half-Level Flag

This block is a first-in first-out buffer nine bits wide. Its depth is a power-of-two parameter, from 512 to 8192 words. It runs in one clock domain. Writers and readers drive active-low strobes. The block samples each strobe on every clock, and an operation takes effect on the release of its strobe, which is the first sample that is high after a low sample. Three active-low status outputs report an empty buffer, a full buffer and a buffer holding more than half its depth.

A rewind input moves the read position back to the first physical location. The write position and the stored words are left as they were, so everything written since reset can be read again. The flags are recomputed from the word count that results. Storage is a simple dual-port array with a registered read port, so an FPGA can map it onto block RAM. The read port always presents the word at the head of the buffer, and a reader samples the output while its strobe is low.

Top module: `fifo_rt`

## Requirements
- R1: While `rst` is high at a clock edge, the read and write positions both return to location zero. After that edge `empty_n` is 0, `full_n` is 1 and `half_n` is 1, and the first word written afterwards is the first word read.
- R2: A write takes effect at the edge where `wr_n` is sampled 1 after being sampled 0 at the previous edge, and the word stored is `din` at that edge. If `full_n` is 0 at that edge, the write is discarded and the stored contents stay unchanged.
- R3: A read takes effect at the edge where `rd_n` is sampled 1 after being sampled 0 at the previous edge, and it removes the oldest word. If `empty_n` is 0 at that edge, the read is ignored and the read position does not move.
- R4: While the buffer holds at least one word, `dout` shows the oldest stored word no later than one clock after the edge that last changed the buffer. It holds that value for as long as `rd_n` stays low.
- R5: `empty_n` is 0 exactly when the word count is zero, and `full_n` is 0 exactly when the count equals DEPTH. Both are registered and change at the same edge that completes the operation.
- R6: `half_n` is 0 exactly when the count is greater than DEPTH/2. It falls at the write that takes the count above DEPTH/2 and rises at the read that brings the count back to DEPTH/2.
- R7: When a read and a write are released at the same edge and the count is between 1 and DEPTH-1, both take effect and the count is unchanged.
- R8: When `rewind_n` is sampled 0, the read position becomes location zero and the write position and stored words are unchanged. A read released at that edge is ignored, a write released at that edge still takes effect, and the flags follow the new count. Rewind is meaningful while no more than DEPTH words have been written since reset.
- R9: A word written into an empty buffer makes `empty_n` 1 at that edge and can then be read, after which `empty_n` returns to 0. A read from a full buffer makes `full_n` 1, and a write that was held low is then stored when it is released, which makes `full_n` 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low; the write takes effect on release |
| rd_n | input | 1 | Read strobe, active low; the read takes effect on release |
| rewind_n | input | 1 | Retransmit request, active low, sampled level |
| din | input | W | Word to store |
| dout | output | W | Oldest stored word (registered) |
| empty_n | output | 1 | Low when the buffer is empty |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| half_n | output | 1 | Low when more than DEPTH/2 words are held |

## Verification
The bench fills the buffer to DEPTH and then tries one more write. A design that accepted that write would overwrite the head word, and the drain that follows would read back corrupt data. The half-level crossing is exercised in both directions. A comparison against a threshold of "at least half" instead of "more than half" would move the falling edge of `half_n` one write too early. Both flow-through cases are covered: a write into an empty buffer with an immediate read, and a write strobe held low across a read from a full buffer. A design that looked at the strobe level instead of its release, or at a stale flag, would store twice or drop the word. A rewind after partial reads must replay every word from the first one. A design that also reset the write position would present an empty buffer, and one that let a read through in the same cycle would skip the first word.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  localparam int WORD_W = 9;

  // Pointer width with one wrap bit, so that full and empty can be told apart
  function automatic int ptr_width(input int depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/fifo_rt_release.sv
module fifo_rt_release (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic released
);
  logic prev_n;

  always_ff @(posedge clk) begin
    if (rst) prev_n <= 1'b1;
    else     prev_n <= strobe_n;
  end

  // The strobe was low at the last edge and is high now
  assign released = !prev_n && strobe_n;
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int DEPTH = 512,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= store[raddr];
  end
endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = fifo_rt_pkg::ptr_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_rel,
  input  logic          rd_rel,
  input  logic          rewind_n,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  logic [PW-1:0] wp, rp, wp_nx, rp_nx, cnt_nx;
  logic          wr_ok, rd_ok;

  assign wr_ok  = wr_rel && full_n;
  assign rd_ok  = rd_rel && empty_n && rewind_n;
  assign wp_nx  = wp + PW'(wr_ok);
  assign rp_nx  = !rewind_n ? '0 : rp + PW'(rd_ok);
  assign cnt_nx = wp_nx - rp_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      empty_n <= 1'b0;
      full_n  <= 1'b1;
      half_n  <= 1'b1;
    end else begin
      wp      <= wp_nx;
      rp      <= rp_nx;
      empty_n <= (cnt_nx != '0);
      full_n  <= (cnt_nx != FULL_CNT);
      half_n  <= !(cnt_nx > HALF_CNT);
    end
  end

  assign wr_en   = wr_ok;
  assign wr_addr = wp[AW-1:0];
  assign rd_addr = rp[AW-1:0];

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!empty_n && !full_n));
  // R6
  full_implies_half_chk: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !half_n);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_rel && !full_n) |=> $stable(wp));
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_rel && !empty_n && rewind_n) |=> $stable(rp));
  // R8
  rewind_keeps_wp_chk: assert property (@(posedge clk) disable iff (rst)
    (!rewind_n && !wr_rel) |=> $stable(wp));
  // R8
  rewind_home_chk: assert property (@(posedge clk) disable iff (rst)
    !rewind_n |=> (rp == '0));
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int DEPTH = 512,
  parameter int W     = fifo_rt_pkg::WORD_W,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic         rewind_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty_n,
  output logic         full_n,
  output logic         half_n
);
  logic          wr_rel, rd_rel, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;

  fifo_rt_release u_wr_rel (.clk(clk), .rst(rst), .strobe_n(wr_n), .released(wr_rel));
  fifo_rt_release u_rd_rel (.clk(clk), .rst(rst), .strobe_n(rd_n), .released(rd_rel));

  fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_rel(wr_rel), .rd_rel(rd_rel), .rewind_n(rewind_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  fifo_rt_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(din),
    .raddr(rd_addr), .rdata(dout)
  );

  // R5
  depth_legal_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (DEPTH == (1 << AW)));
endmodule

// File: tb/fifo_rt_test.sv
module fifo_rt_test;
  localparam int DEPTH = 512;
  localparam int W     = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_n = 1'b1, rd_n = 1'b1, rewind_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic empty_n, full_n, half_n;

  int vectors = 0;
  int miscompares = 0;
  bit running = 1'b0;

  always #5 clk = ~clk;

  fifo_rt #(.DEPTH(DEPTH), .W(W)) uut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rewind_n(rewind_n),
    .din(din), .dout(dout), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  // Behavioural reference: live contents plus everything written since reset
  logic [W-1:0] q[$];
  logic [W-1:0] hist[$];
  logic pw = 1'b1, pr = 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); hist.delete();
      pw = 1'b1; pr = 1'b1;
    end else begin
      automatic bit wrel = !pw && wr_n;
      automatic bit rrel = !pr && rd_n;
      automatic bit was_full  = (q.size() == DEPTH);
      automatic bit was_empty = (q.size() == 0);
      if (!rewind_n) q = hist;
      else if (rrel && !was_empty) void'(q.pop_front());
      if (wrel && !was_full) begin
        q.push_back(din);
        hist.push_back(din);
      end
      pw = wr_n; pr = rd_n;
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Every-cycle flag comparison (R5, R6)
  always @(negedge clk) begin
    if (running && !rst) begin
      check("R5", int'(empty_n), int'(q.size() != 0), "empty_n");
      check("R5", int'(full_n), int'(q.size() != DEPTH), "full_n");
      check("R6", int'(half_n), int'(!(q.size() > DEPTH/2)), "half_n");
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic head_check(string tag);
    if (q.size() != 0) check(tag, int'(dout), int'(q[0]), "dout");
  endtask

  task automatic do_write(logic [W-1:0] d);
    wr_n = 1'b0; din = d; cyc(2);
    wr_n = 1'b1; cyc(1);
  endtask

  task automatic do_read(string tag);
    rd_n = 1'b0; cyc(3);
    head_check(tag);
    rd_n = 1'b1; cyc(1);
  endtask

  task automatic do_both(logic [W-1:0] d);
    wr_n = 1'b0; rd_n = 1'b0; din = d; cyc(3);
    head_check("R7");
    wr_n = 1'b1; rd_n = 1'b1; cyc(1);
  endtask

  task automatic do_reset;
    rst = 1'b1; wr_n = 1'b1; rd_n = 1'b1; rewind_n = 1'b1; cyc(2);
    rst = 1'b0; cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cyc(1);
    do_reset();
    running = 1'b1;
    // R1 reset state
    check("R1", int'(empty_n), 0, "empty_n after reset");
    check("R1", int'(full_n), 1, "full_n after reset");
    check("R1", int'(half_n), 1, "half_n after reset");

    // R2 R3 R4 basic order
    do_write(9'h011); do_write(9'h122); do_write(9'h033);
    do_read("R4"); do_read("R3"); do_read("R4");
    check("R3", int'(empty_n), 0, "empty after drain");

    // R3 read from empty is ignored
    do_read("R3");
    check("R3", int'(empty_n), 0, "empty after empty read");
    do_write(9'h055);
    rd_n = 1'b0; cyc(3);
    check("R3", int'(dout), 9'h055, "head after ignored read");
    rd_n = 1'b1; cyc(1);

    // R9 read flow-through
    do_write(9'h1A5);
    check("R9", int'(empty_n), 1, "empty_n after write into empty");
    do_read("R9");
    check("R9", int'(empty_n), 0, "empty_n after flow-through read");

    // R7 simultaneous read and write
    do_write(9'h001); do_write(9'h002);
    do_both(9'h003); do_both(9'h004);
    do_read("R7"); do_read("R7");
    check("R7", int'(empty_n), 0, "empty after simultaneous ops");

    // R8 rewind replays from the first word
    do_reset();
    for (int i = 0; i < 10; i++) do_write(W'(i * 7 + 1));
    for (int i = 0; i < 4; i++) do_read("R4");
    rewind_n = 1'b0; cyc(1); rewind_n = 1'b1; cyc(1);
    rd_n = 1'b0; cyc(3);
    check("R8", int'(dout), 1, "first word after rewind");
    rd_n = 1'b1; cyc(1);
    for (int i = 1; i < 10; i++) do_read("R8");
    check("R8", int'(empty_n), 0, "empty after replay");
    // R8 read released during rewind is ignored
    rd_n = 1'b0; cyc(2);
    rd_n = 1'b1; rewind_n = 1'b0; cyc(1); rewind_n = 1'b1; cyc(1);
    rd_n = 1'b0; cyc(3);
    check("R8", int'(dout), 1, "read during rewind ignored");
    rd_n = 1'b1; cyc(1);

    // R6 threshold, R2 full write ignored, R9 write flow-through
    do_reset();
    for (int i = 0; i < DEPTH/2; i++) do_write(W'(i + 3));
    check("R6", int'(half_n), 1, "half_n at exactly half");
    do_write(9'h0F0);
    check("R6", int'(half_n), 0, "half_n above half");
    do_read("R6");
    check("R6", int'(half_n), 1, "half_n back at half");
    while (q.size() < DEPTH) do_write(W'(q.size() * 3));
    check("R5", int'(full_n), 0, "full_n when full");
    do_write(9'h1FF);
    check("R2", int'(full_n), 0, "full after ignored write");
    wr_n = 1'b0; din = 9'h0AA;
    do_read("R9");
    check("R9", int'(full_n), 1, "full_n after read from full");
    wr_n = 1'b1; cyc(1);
    check("R9", int'(full_n), 0, "full_n after pending write");
    while (q.size() > 1) do_read("R4");
    rd_n = 1'b0; cyc(3);
    check("R9", int'(dout), 9'h0AA, "last word is the flow-through write");
    rd_n = 1'b1; cyc(1);
    check("R5", int'(empty_n), 0, "empty after full drain");

    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule